// File: doc/BRIEF.md
# Time-Domain Reflectometry Pulse and Echo Monitor

This block runs one time-domain reflectometry measurement on a twisted-pair cable. It is clocked at 8 ns. When enabled and asked to start, it drives a pulse-enable output on one chosen pair for a programmed number of clocks. The pulse is sent with a sign that alternates from run to run in fast mode. In the same cycle as the pulse, an 8-bit time counter starts from zero. The analog drivers and the converter sit outside the block: the block only raises drive enables and reads signed 8-bit samples from both pairs.

During the run, the block watches the samples of the monitored pair. Only samples whose time lies within a start/stop window are looked at. For those samples it keeps the most extreme value and the time it first occurred; the extreme is the largest value in max mode or the smallest in min mode. It also keeps the time of the first sample that goes past a programmed threshold. Once the stop time has been processed, the block raises a done flag and holds every result until the next accepted start. A pulse width of zero makes a baseline run: the monitor runs but no pulse is sent.

Top module: `tdr_probe`

## Requirements
- R1: After synchronous reset, busy, done, all drive outputs, no_cross, peak_val, peak_time and thr_time are all 0.
- R2: A start is accepted only on a clock edge where enable=1, start=1 and busy=0. A start while disabled or while busy changes no output and no result.
- R3: The pulse enable is high for exactly pulse_width cycles (0 to 7). These begin in the first cycle after acceptance, which is time 0. drive_tx is used when send_rx=0 and drive_rx when send_rx=1, and the two are never high together. A width of 0 drives nothing.
- R4: drive_neg is high only while a pulse is being driven. With fast_mode=0 it stays 0. With fast_mode=1, runs that have a non-zero width alternate their sign, and the first one after reset is positive (drive_neg=0). Zero-width runs and fast_mode=0 runs do not advance the alternation.
- R5: The cycle that carries time t qualifies its sample only when win_start <= t <= win_stop, with unsigned compare. When win_stop < win_start, no sample is qualified.
- R6: The monitored sample is sample_tx when mon_rx=0 and sample_rx when mon_rx=1. The choice is latched at acceptance.
- R7: A run starts with peak_val at -128 in max mode (min_mode=0) or +127 in min mode, and with peak_time at 0. A qualified sample replaces the peak only when it is strictly greater (max mode) or strictly less (min mode). A later equal sample does not move peak_time.
- R8: thr_time is the time of the first qualified sample that is strictly above threshold (max mode) or strictly below it (min mode). A sample equal to the threshold is not a crossing.
- R9: busy lasts win_stop+1 cycles after acceptance. done rises in the cycle after time win_stop and is cleared by the next accepted start. Results do not change while idle.
- R10: When a run completes with no crossing, no_cross is set together with done, and thr_time stays 0.
- R11: Dropping enable during a run aborts it. From the next cycle, busy and all drives are 0 and done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 ns clock |
| rst | input | 1 | synchronous active-high reset |
| enable | input | 1 | function enable; low aborts a run |
| start | input | 1 | send pulse and start monitor |
| fast_mode | input | 1 | fast-driver mode: alternate pulse sign |
| pulse_width | input | 3 | pulse length in clocks, 0 = baseline |
| send_rx | input | 1 | 0 = send on transmit pair, 1 = on receive pair |
| mon_rx | input | 1 | 0 = monitor transmit pair, 1 = receive pair |
| min_mode | input | 1 | 0 = track maximum, 1 = track minimum |
| win_start | input | 8 | first qualified time |
| win_stop | input | 8 | last qualified time, also ends the run |
| threshold | input | 8 | signed crossing threshold |
| sample_tx | input | 8 | signed sample of transmit pair |
| sample_rx | input | 8 | signed sample of receive pair |
| drive_tx | output | 1 | pulse enable, transmit pair |
| drive_rx | output | 1 | pulse enable, receive pair |
| drive_neg | output | 1 | pulse sign, 1 = negative |
| busy | output | 1 | run in progress |
| done | output | 1 | run completed, results valid |
| peak_val | output | 8 | signed extreme value |
| peak_time | output | 8 | time of first occurrence of extreme |
| thr_time | output | 8 | time of first threshold crossing |
| no_cross | output | 1 | run finished without crossing |

## Verification
The checker watches, on every cycle, that the drive outputs stay exclusive, that the sign output appears only with a drive, and that drives happen only inside a run. It also checks that done and busy exclude each other, that results stay frozen while idle, that no_cross appears only with done, and that a disabled block becomes idle. The values themselves can only be shown by bench scenarios that compare against a model computed from known sample arrays. These values are the peak with its first-occurrence time under ties, a threshold equal to a sample, windows that are empty or reversed, the monitored-pair choice, sign alternation across runs, and the exact pulse length.

// File: rtl/tdr_probe_pkg.sv
package tdr_probe_pkg;
    localparam int SMP_W  = 8;
    localparam int TIME_W = 8;
    localparam int PW_W   = 3;

    localparam logic signed [SMP_W-1:0] SMP_MAX = (SMP_W)'((1 << (SMP_W-1)) - 1);
    localparam logic signed [SMP_W-1:0] SMP_MIN = ~SMP_MAX;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic [TIME_W-1:0]       tick_t;
    typedef logic [PW_W-1:0]         pw_t;

    typedef struct packed {
        pw_t   width;
        logic  send_rx;
        logic  mon_rx;
        logic  min_mode;
        logic  fast;
        tick_t win_lo;
        tick_t win_hi;
        smp_t  thr;
    } run_cfg_t;

    // true when a is strictly more extreme than b in the selected direction
    function automatic logic beats(input logic use_min, input smp_t a, input smp_t b);
        return use_min ? (a < b) : (a > b);
    endfunction

    function automatic smp_t peak_seed(input logic use_min);
        return use_min ? SMP_MAX : SMP_MIN;
    endfunction
endpackage

// File: rtl/tdr_seq.sv
module tdr_seq
    import tdr_probe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     start,
    input  run_cfg_t cfg_in,
    output run_cfg_t cfg_q,
    output tick_t    tick,
    output logic     busy,
    output logic     done,
    output logic     accept,
    output logic     qualify,
    output logic     last,
    output logic     drive_tx,
    output logic     drive_rx,
    output logic     drive_neg
);
    logic  pol_q;
    logic  run_neg_q;
    logic  pulse_on;
    logic  at_stop;

    assign accept  = enable && start && !busy;
    assign at_stop = (tick == cfg_q.win_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            tick      <= '0;
            cfg_q     <= '0;
            pol_q     <= 1'b0;
            run_neg_q <= 1'b0;
        end else if (busy && !enable) begin
            busy <= 1'b0;
        end else if (accept) begin
            busy      <= 1'b1;
            done      <= 1'b0;
            tick      <= '0;
            cfg_q     <= cfg_in;
            run_neg_q <= cfg_in.fast & pol_q;
            if (cfg_in.fast && (cfg_in.width != '0))
                pol_q <= ~pol_q;
        end else if (busy) begin
            if (at_stop) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    assign pulse_on  = busy && (tick < tick_t'(cfg_q.width));
    assign drive_tx  = pulse_on && !cfg_q.send_rx;
    assign drive_rx  = pulse_on &&  cfg_q.send_rx;
    assign drive_neg = pulse_on && run_neg_q;

    assign qualify = busy && enable && (tick >= cfg_q.win_lo) && (tick <= cfg_q.win_hi);
    assign last    = busy && enable && at_stop;
endmodule

// File: rtl/tdr_capture.sv
module tdr_capture
    import tdr_probe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  clear_min,
    input  logic  use_min,
    input  smp_t  thr,
    input  logic  qualify,
    input  logic  last,
    input  smp_t  smp,
    input  tick_t tick,
    output smp_t  peak_val,
    output tick_t peak_time,
    output tick_t thr_time,
    output logic  no_cross
);
    logic found_q;
    logic cross_now;

    assign cross_now = qualify && !found_q && beats(use_min, smp, thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            peak_val  <= '0;
            peak_time <= '0;
            thr_time  <= '0;
            found_q   <= 1'b0;
            no_cross  <= 1'b0;
        end else if (clear) begin
            peak_val  <= peak_seed(clear_min);
            peak_time <= '0;
            thr_time  <= '0;
            found_q   <= 1'b0;
            no_cross  <= 1'b0;
        end else begin
            if (qualify && beats(use_min, smp, peak_val)) begin
                peak_val  <= smp;
                peak_time <= tick;
            end
            if (cross_now) begin
                found_q  <= 1'b1;
                thr_time <= tick;
            end
            if (last)
                no_cross <= !(found_q || cross_now);
        end
    end
endmodule

// File: rtl/tdr_probe.sv
module tdr_probe
    import tdr_probe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        start,
    input  logic        fast_mode,
    input  logic [2:0]  pulse_width,
    input  logic        send_rx,
    input  logic        mon_rx,
    input  logic        min_mode,
    input  logic [7:0]  win_start,
    input  logic [7:0]  win_stop,
    input  logic [7:0]  threshold,
    input  logic [7:0]  sample_tx,
    input  logic [7:0]  sample_rx,
    output logic        drive_tx,
    output logic        drive_rx,
    output logic        drive_neg,
    output logic        busy,
    output logic        done,
    output logic [7:0]  peak_val,
    output logic [7:0]  peak_time,
    output logic [7:0]  thr_time,
    output logic        no_cross
);
    run_cfg_t cfg_in, cfg_q;
    tick_t    tick;
    logic     accept, qualify, last;
    smp_t     smp_sel;
    smp_t     peak_s;

    always_comb begin
        cfg_in.width    = pulse_width;
        cfg_in.send_rx  = send_rx;
        cfg_in.mon_rx   = mon_rx;
        cfg_in.min_mode = min_mode;
        cfg_in.fast     = fast_mode;
        cfg_in.win_lo   = win_start;
        cfg_in.win_hi   = win_stop;
        cfg_in.thr      = smp_t'(threshold);
    end

    assign smp_sel = cfg_q.mon_rx ? smp_t'(sample_rx) : smp_t'(sample_tx);

    tdr_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .start     (start),
        .cfg_in    (cfg_in),
        .cfg_q     (cfg_q),
        .tick      (tick),
        .busy      (busy),
        .done      (done),
        .accept    (accept),
        .qualify   (qualify),
        .last      (last),
        .drive_tx  (drive_tx),
        .drive_rx  (drive_rx),
        .drive_neg (drive_neg)
    );

    tdr_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .clear_min (min_mode),
        .use_min   (cfg_q.min_mode),
        .thr       (cfg_q.thr),
        .qualify   (qualify),
        .last      (last),
        .smp       (smp_sel),
        .tick      (tick),
        .peak_val  (peak_s),
        .peak_time (peak_time),
        .thr_time  (thr_time),
        .no_cross  (no_cross)
    );

    assign peak_val = peak_s;
endmodule

// File: rtl/tdr_probe_chk.sv
module tdr_probe_chk (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic       start,
    input logic       drive_tx,
    input logic       drive_rx,
    input logic       drive_neg,
    input logic       busy,
    input logic       done,
    input logic [7:0] peak_val,
    input logic [7:0] peak_time,
    input logic [7:0] thr_time,
    input logic       no_cross
);
    assert_pair_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(drive_tx && drive_rx));

    assert_drive_in_run_R3: assert property (@(posedge clk) disable iff (rst)
        (drive_tx || drive_rx) |-> busy);

    assert_sign_with_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        drive_neg |-> (drive_tx || drive_rx));

    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
        !(done && busy));

    assert_done_after_run_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(peak_val) && $stable(peak_time)
                               && $stable(thr_time) && $stable(done)));

    assert_idle_ignore_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !enable) |=> !busy);

    assert_nocross_done_R10: assert property (@(posedge clk) disable iff (rst)
        no_cross |-> done);

    assert_abort_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && !enable) |=> (!busy && !done));
endmodule

bind tdr_probe tdr_probe_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .start     (start),
    .drive_tx  (drive_tx),
    .drive_rx  (drive_rx),
    .drive_neg (drive_neg),
    .busy      (busy),
    .done      (done),
    .peak_val  (peak_val),
    .peak_time (peak_time),
    .thr_time  (thr_time),
    .no_cross  (no_cross)
);

// File: tb/tb_tdr_probe.sv
module tb_tdr_probe;
    logic clk = 1'b0;
    logic rst;
    logic enable, start, fast_mode, send_rx, mon_rx, min_mode;
    logic [2:0] pulse_width;
    logic [7:0] win_start, win_stop, threshold, sample_tx, sample_rx;
    logic drive_tx, drive_rx, drive_neg, busy, done, no_cross;
    logic [7:0] peak_val, peak_time, thr_time;

    int checks = 0;
    int errors = 0;
    logic exp_pol = 1'b0;
    logic signed [7:0] arr_tx [256];
    logic signed [7:0] arr_rx [256];

    always #4 clk = ~clk;

    tdr_probe dut (
        .clk(clk), .rst(rst), .enable(enable), .start(start), .fast_mode(fast_mode),
        .pulse_width(pulse_width), .send_rx(send_rx), .mon_rx(mon_rx), .min_mode(min_mode),
        .win_start(win_start), .win_stop(win_stop), .threshold(threshold),
        .sample_tx(sample_tx), .sample_rx(sample_rx),
        .drive_tx(drive_tx), .drive_rx(drive_rx), .drive_neg(drive_neg),
        .busy(busy), .done(done), .peak_val(peak_val), .peak_time(peak_time),
        .thr_time(thr_time), .no_cross(no_cross)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic more(input logic mn, input logic signed [7:0] a,
                                  input logic signed [7:0] b);
        return mn ? (a < b) : (a > b);
    endfunction

    task automatic fill_random();
        for (int i = 0; i < 256; i++) begin
            arr_tx[i] = 8'($urandom);
            arr_rx[i] = 8'($urandom);
        end
    endtask

    task automatic fill_const(input logic signed [7:0] v);
        for (int i = 0; i < 256; i++) begin
            arr_tx[i] = v;
            arr_rx[i] = v;
        end
    endtask

    // one full run, with an optional stray start inside it (R2)
    task automatic run(input int w, input bit sr, input bit mr, input bit mn,
                       input bit fst, input int ws, input int we,
                       input logic signed [7:0] thr, input bit poke);
        logic signed [7:0] pk, s;
        int pt, tt;
        bit found, neg;
        pk = mn ? 8'sd127 : -8'sd128;
        pt = 0; tt = 0; found = 0;
        for (int t = 0; t < 256; t++) begin
            if (t >= ws && t <= we) begin
                s = mr ? arr_rx[t] : arr_tx[t];
                if (more(mn, s, pk)) begin pk = s; pt = t; end
                if (!found && more(mn, s, thr)) begin found = 1; tt = t; end
            end
        end
        neg = fst ? exp_pol : 1'b0;
        if (fst && w != 0) exp_pol = ~exp_pol;

        @(negedge clk);
        enable = 1; start = 1; pulse_width = 3'(w); send_rx = sr; mon_rx = mr;
        min_mode = mn; fast_mode = fst; win_start = 8'(ws); win_stop = 8'(we);
        threshold = thr;
        for (int t = 0; t <= we; t++) begin
            @(negedge clk);
            start = (poke && t == 1);
            pulse_width = 3'($urandom); min_mode = $urandom; mon_rx = $urandom;
            sample_tx = arr_tx[t]; sample_rx = arr_rx[t];
            chk(busy == 1'b1, "R9 busy in run", busy, 1);
            chk(drive_tx == (t < w && !sr), "R3 drive_tx", drive_tx, (t < w && !sr));
            chk(drive_rx == (t < w && sr), "R3 drive_rx", drive_rx, (t < w && sr));
            chk(drive_neg == (t < w && neg), "R4 drive_neg", drive_neg, (t < w && neg));
        end
        @(negedge clk);
        start = 0;
        chk(busy == 0 && done == 1, "R9 done after stop", {busy, done}, 1);
        chk($signed(peak_val) == pk, "R7 R5 R6 peak_val", $signed(peak_val), pk);
        chk(peak_time == 8'(pt), "R7 peak_time", peak_time, pt);
        chk(thr_time == 8'(tt), "R8 thr_time", thr_time, tt);
        chk(no_cross == !found, "R10 no_cross", no_cross, !found);
        repeat (2) @(negedge clk);
        chk($signed(peak_val) == pk && done, "R9 results held", $signed(peak_val), pk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; enable = 0; start = 0; fast_mode = 0; pulse_width = 0; send_rx = 0;
        mon_rx = 0; min_mode = 0; win_start = 0; win_stop = 8'd255; threshold = 0;
        sample_tx = 0; sample_rx = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk({busy, done, drive_tx, drive_rx, drive_neg, no_cross} == 6'b0, "R1 flags",
            {busy, done, drive_tx, drive_rx, drive_neg, no_cross}, 0);
        chk(peak_val == 0 && peak_time == 0 && thr_time == 0, "R1 results", peak_val, 0);

        // R2 start while disabled is ignored
        start = 1; enable = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !drive_tx && !done, "R2 disabled start", busy, 0);
        start = 0;

        // R7 ties: equal samples keep the first time; baseline width 0 (R3)
        fill_const(8'sd5);
        run(0, 0, 0, 0, 0, 10, 40, 8'sd20, 0);
        // R8 R10 threshold equal to samples is no crossing
        run(2, 1, 1, 1, 0, 0, 30, 8'sd5, 0);
        // R5 reversed window: nothing qualified
        fill_random();
        run(1, 0, 1, 0, 0, 50, 20, -8'sd100, 0);
        // R4 alternation in fast mode, zero width does not advance
        run(3, 0, 0, 0, 1, 0, 12, 8'sd0, 0);
        run(0, 0, 0, 0, 1, 0, 12, 8'sd0, 0);
        run(3, 1, 0, 0, 1, 0, 12, 8'sd0, 0);
        run(7, 0, 1, 1, 1, 0, 12, 8'sd0, 0);
        // R2 start during a run is ignored; R6 monitor each pair
        run(5, 0, 1, 0, 0, 2, 60, 8'sd30, 1);
        run(5, 1, 0, 1, 0, 2, 60, -8'sd30, 1);
        // full window
        run(4, 0, 0, 0, 0, 0, 255, 8'sd100, 0);

        // R11 abort by dropping enable
        @(negedge clk);
        enable = 1; start = 1; pulse_width = 3'd7; win_start = 0; win_stop = 8'd60;
        fast_mode = 0;
        @(negedge clk);
        start = 0;
        repeat (2) @(negedge clk);
        enable = 0;
        @(negedge clk);
        chk(!busy && !drive_tx && !drive_rx && !done, "R11 abort", {busy, done}, 0);
        enable = 1;

        for (int i = 0; i < 30; i++) begin
            int ws, we;
            fill_random();
            ws = $urandom_range(0, 120);
            we = $urandom_range(0, 200);
            run($urandom_range(0, 7), $urandom, $urandom, $urandom, $urandom,
                ws, we, 8'($urandom), $urandom_range(0, 3) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule